// File: doc/BRIEF.md
# Multi-Mode Pooling Engine

This block shrinks a feature map that sits in on-chip memory. The map is cut into non-overlapping square windows of side K, where K is 2 or 3. Each window of each channel becomes one output value. The reduction is chosen at run time: signed maximum, rounded average, or full-precision sum. P channels travel side by side in one memory word, so one read brings in one spatial position for P channels at once. No weights are involved, and the output map has as many channels as the input map.

A controller loads the input height, width and channel count, the window select and the method, and then pulses `start`. The engine walks the windows in a fixed order. It reads the input memory through a port with one cycle of latency and writes each finished output word to the output memory through a write port. The address of an input word is `(row*Win + col)*G + g` and the address of an output word is `(orow*Wout + ocol)*G + g`, where `G = Cin/P`. When the last write has been made, `done` pulses for one cycle.

Top module: `pool_engine`

## Requirements
- R1: A `start` pulse while idle captures `hin`, `win`, `cin`, `k_sel` and `method` and raises `busy`. While `busy` is high, a further `start` and any change to these inputs have no effect on the run in progress. `busy` falls in the cycle in which `done` is high.
- R2: Input word `(r*Win + c)*G + g` holds position (r, c) of channel group g, with `G = cin/P`. The engine writes output words in increasing address order from 0, one write per output word, and makes exactly `Hout*Wout*G` writes.
- R3: `method` 2'b00 selects the signed maximum of the window. The reserved code 2'b11 behaves exactly like 2'b00. The result is correct even when every element of the window is negative.
- R4: `method` 2'b01 with K=2 writes floor((S+2)/4), where S is the window sum.
- R5: `method` 2'b01 with K=3 writes floor((S+4)/9), where S is the window sum.
- R6: `method` 2'b10 writes the exact window sum as a signed value DW+4 bits wide. A window of nine -2^(DW-1) values, or of nine 2^(DW-1)-1 values, does not overflow.
- R7: The output size is Hout = floor(Hin/K) and Wout = floor(Win/K). Input rows and columns past the last whole window are never used.
- R8: Lane i takes input bits `[i*DW +: DW]` and writes output bits `[i*OW +: OW]`, with OW = DW+4. Each lane is reduced on its own.
- R9: `done` is a one-cycle pulse that comes after the last write of a run. If Hin<K, Win<K or Cin<P, the run makes no write and `done` still pulses.
- R10: While reset is asserted, `busy`, `done`, `rd_en` and `wr_en` are low.
- R11: `k_sel` 0 selects K=2 and `k_sel` 1 selects K=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when the engine is idle |
| hin | input | DIM_W | Input height |
| win | input | DIM_W | Input width |
| cin | input | DIM_W | Input channel count, a multiple of P |
| k_sel | input | 1 | Window side: 0 for 2, 1 for 3 |
| method | input | 2 | 00 max, 01 average, 10 sum, 11 max |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| rd_en | output | 1 | Input memory read strobe |
| rd_addr | output | AW | Input memory word address |
| rd_data | input | P*DW | Input word, valid one cycle after rd_en |
| wr_en | output | 1 | Output memory write strobe |
| wr_addr | output | AW | Output memory word address |
| wr_data | output | P*(DW+4) | Output word, P signed results |

## Verification
The bench targets these corner cases:
- A window made only of negative values. A maximum that started its accumulator at zero would write 0 instead of the true maximum.
- Windows made only of the extreme values. A sum that kept only DW bits would wrap around.
- Negative sums in average mode. A design that truncated toward zero, or that used an inexact reciprocal for K=3, would be off by one.
- Odd sizes such as 5x5 and 7x6. A design that did not drop the partial windows would write too many words.
- Runs with no whole window at all. Any write in such a run is an error.
- A second start, with different settings, during a run. A design that accepted it would change the results of the run in progress.

// File: rtl/pool_engine.sv
module pool_engine #(
  parameter int P     = 4,
  parameter int DW    = 8,
  parameter int DIM_W = 8,
  parameter int AW    = 12
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [DIM_W-1:0]   hin,
  input  logic [DIM_W-1:0]   win,
  input  logic [DIM_W-1:0]   cin,
  input  logic               k_sel,
  input  logic [1:0]         method,
  output logic               busy,
  output logic               done,
  output logic               rd_en,
  output logic [AW-1:0]      rd_addr,
  input  logic [P*DW-1:0]    rd_data,
  output logic               wr_en,
  output logic [AW-1:0]      wr_addr,
  output logic [P*(DW+4)-1:0] wr_data
);
  localparam int OW    = DW + 4;
  localparam int LP    = $clog2(P);
  localparam int CW    = DIM_W + 1;
  localparam int SH    = DW + 11;
  localparam int XW    = DW + 8;
  localparam int BIAS  = 2 ** (DW + 3);
  localparam int RECIP = (2 ** SH + 8) / 9;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} st_t;
  st_t state;

  logic [DIM_W-1:0] hin_q, win_q, grp_q, cg;
  logic             k3_q;
  logic [1:0]       meth_q, kx, ky;
  logic [CW-1:0]    rbase, cbase;
  logic             v1, first1, last1;
  logic [AW-1:0]    optr, pix;
  logic [P*OW-1:0]  res;

  logic [CW-1:0]    kk, kin;
  logic [1:0]       kmax;
  logic [DIM_W-1:0] grp_in;
  logic             empty, kx_last, ky_last, cg_last, col_last, row_last;
  logic             is_avg, is_sum;

  assign kk       = k3_q ? CW'(3) : CW'(2);
  assign kmax     = k3_q ? 2'd2 : 2'd1;
  assign kin      = k_sel ? CW'(3) : CW'(2);
  assign grp_in   = cin >> LP;
  assign empty    = (CW'(hin) < kin) || (CW'(win) < kin) || (grp_in == '0);
  assign kx_last  = kx == kmax;
  assign ky_last  = ky == kmax;
  assign cg_last  = cg == grp_q - DIM_W'(1);
  assign col_last = (cbase + kk + kk) > CW'(win_q);
  assign row_last = (rbase + kk + kk) > CW'(hin_q);
  assign is_avg   = meth_q == 2'b01;
  assign is_sum   = meth_q == 2'b10;

  assign busy    = state != S_IDLE;
  assign rd_en   = state == S_RUN;
  assign pix     = (AW'(rbase) + AW'(ky)) * AW'(win_q) + AW'(cbase) + AW'(kx);
  assign rd_addr = pix * AW'(grp_q) + AW'(cg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      hin_q  <= '0;
      win_q  <= '0;
      grp_q  <= '0;
      k3_q   <= 1'b0;
      meth_q <= 2'b00;
      kx     <= '0;
      ky     <= '0;
      cg     <= '0;
      rbase  <= '0;
      cbase  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          hin_q  <= hin;
          win_q  <= win;
          grp_q  <= grp_in;
          k3_q   <= k_sel;
          meth_q <= method;
          kx     <= '0;
          ky     <= '0;
          cg     <= '0;
          rbase  <= '0;
          cbase  <= '0;
          state  <= empty ? S_DRAIN : S_RUN;
        end
        S_RUN: begin
          if (!kx_last) kx <= kx + 2'd1;
          else begin
            kx <= '0;
            if (!ky_last) ky <= ky + 2'd1;
            else begin
              ky <= '0;
              if (!cg_last) cg <= cg + DIM_W'(1);
              else begin
                cg <= '0;
                if (!col_last) cbase <= cbase + kk;
                else begin
                  cbase <= '0;
                  if (row_last) state <= S_DRAIN;
                  else rbase <= rbase + kk;
                end
              end
            end
          end
        end
        default: if (!v1) begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1      <= 1'b0;
      first1  <= 1'b0;
      last1   <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      optr    <= '0;
    end else begin
      v1     <= rd_en;
      first1 <= kx == 2'd0 && ky == 2'd0;
      last1  <= kx_last && ky_last;
      wr_en  <= v1 && last1;
      if (state == S_IDLE && start) optr <= '0;
      if (v1 && last1) begin
        wr_data <= res;
        wr_addr <= optr;
        optr    <= optr + AW'(1);
      end
    end
  end

  for (genvar i = 0; i < P; i++) begin : g_lane
    logic signed [OW-1:0] d, acc, fin, r2, avg2, avg3;
    logic signed [XW-1:0] biased;

    assign d      = OW'($signed(rd_data[i*DW +: DW]));
    assign fin    = first1 ? d : ((is_avg || is_sum) ? acc + d : ((d > acc) ? d : acc));
    assign r2     = fin + OW'(2);
    assign avg2   = r2 >>> 2;
    assign biased = XW'(fin) + XW'(4 + 9 * BIAS);
    assign avg3   = OW'((((XW+SH)'(biased) * (XW+SH)'(RECIP)) >> SH) - (XW+SH)'(BIAS));
    assign res[i*OW +: OW] = is_avg ? (k3_q ? avg3 : avg2) : fin;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc <= '0;
      else if (v1) acc <= fin;
    end
  end
endmodule

// File: rtl/pool_engine_chk.sv
module pool_engine_chk #(
  parameter int P  = 4,
  parameter int DW = 8
)(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 busy,
  input logic                 done,
  input logic                 rd_en,
  input logic                 wr_en,
  input logic [P*(DW+4)-1:0]  wr_data
);
  localparam int OW = DW + 4;
  localparam int LO = -(9 * (2 ** (DW - 1)));
  localparam int HI = 9 * (2 ** (DW - 1) - 1);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r1_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r1_fall_with_done: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
  a_r2_write_in_run: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> busy);
  a_r2_read_in_run: assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> busy);

  for (genvar i = 0; i < P; i++) begin : g_rng
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ($signed(wr_data[i*OW +: OW]) >= LO && $signed(wr_data[i*OW +: OW]) <= HI));
  end
endmodule

bind pool_engine pool_engine_chk #(.P(P), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data)
);

// File: tb/test_pool_engine.sv
module test_pool_engine;
  localparam int P = 4, DW = 8, OW = DW + 4, DIM_W = 8, AW = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start, k_sel, busy, done, rd_en, wr_en;
  logic [DIM_W-1:0] hin, win, cin;
  logic [1:0] method;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [P*DW-1:0] rd_data;
  logic [P*OW-1:0] wr_data;

  pool_engine #(.P(P), .DW(DW), .DIM_W(DIM_W), .AW(AW)) i_pool_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .hin(hin), .win(win), .cin(cin),
    .k_sel(k_sel), .method(method), .busy(busy), .done(done), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data));

  logic [P*DW-1:0] in_mem [256];
  always @(posedge clk) if (rd_en) rd_data <= in_mem[rd_addr[7:0]];

  int total = 0, fails = 0, done_cnt = 0;
  bit finished = 0;
  int exp_addr[$];
  logic [P*OW-1:0] exp_data[$];
  string cur_req = "R2";

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int fdiv(int a, int b);
    int q = a / b;
    if ((a % b != 0) && (a < 0)) q = q - 1;
    return q;
  endfunction

  always @(negedge clk) if (rst_n) begin
    if (wr_en) begin
      if (exp_addr.size() == 0) check(0, "R2", "extra write", longint'(wr_addr), -1);
      else begin
        check(wr_addr == AW'(exp_addr[0]), "R2", "write address", longint'(wr_addr), longint'(exp_addr[0]));
        check(wr_data == exp_data[0], cur_req, "write data", longint'(wr_data), longint'(exp_data[0]));
        void'(exp_addr.pop_front());
        void'(exp_data.pop_front());
      end
    end
    if (done) begin
      done_cnt++;
      check(exp_addr.size() == 0, "R9", "done before last write", exp_addr.size(), 0);
    end
  end

  task automatic fill(int kind);
    for (int a = 0; a < 256; a++) begin
      logic [P*DW-1:0] w;
      for (int l = 0; l < P; l++) begin
        case (kind)
          1: w[l*DW +: DW] = DW'(8'h80);
          2: w[l*DW +: DW] = DW'(8'h7f);
          3: w[l*DW +: DW] = DW'(8'h80 | ($urandom & 8'h7f));
          default: w[l*DW +: DW] = DW'($urandom);
        endcase
      end
      in_mem[a] = w;
    end
  endtask

  task automatic build(int h, int w, int c, bit ks, logic [1:0] m);
    int k = ks ? 3 : 2;
    int g = c / P;
    int ho = h / k, wo = w / k, oa = 0;
    for (int orow = 0; orow < ho; orow++)
      for (int ocol = 0; ocol < wo; ocol++)
        for (int gi = 0; gi < g; gi++) begin
          logic [P*OW-1:0] ev;
          for (int l = 0; l < P; l++) begin
            int s = 0, mx = 0, r;
            for (int ky = 0; ky < k; ky++)
              for (int kx = 0; kx < k; kx++) begin
                int v = $signed(in_mem[((orow*k + ky)*w + ocol*k + kx)*g + gi][l*DW +: DW]);
                s += v;
                if ((ky == 0 && kx == 0) || v > mx) mx = v;
              end
            if (m == 2'b01) r = (k == 2) ? fdiv(s + 2, 4) : fdiv(s + 4, 9);
            else if (m == 2'b10) r = s;
            else r = mx;
            ev[l*OW +: OW] = OW'(r);
          end
          exp_addr.push_back(oa);
          exp_data.push_back(ev);
          oa++;
        end
  endtask

  task automatic run_case(int h, int w, int c, bit ks, logic [1:0] m, string req, bit interfere);
    int prev = done_cnt, n = 0;
    cur_req = req;
    build(h, w, c, ks, m);
    @(negedge clk);
    hin = DIM_W'(h); win = DIM_W'(w); cin = DIM_W'(c); k_sel = ks; method = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R1", "busy after start", busy, 1);
    if (interfere) begin
      repeat (3) @(negedge clk);
      hin = 9; win = 9; cin = 4; k_sel = ~ks; method = 2'b01; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_cnt == prev && n < 5000) begin
      @(negedge clk); #1; n++;
    end
    check(done_cnt == prev + 1, "R9", "done pulse seen", done_cnt - prev, 1);
    check(busy == 1'b0, "R1", "busy low after done", busy, 0);
    check(exp_addr.size() == 0, "R2", "writes missing", exp_addr.size(), 0);
    exp_addr.delete();
    exp_data.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; hin = '0; win = '0; cin = '0; k_sel = 1'b0; method = 2'b00;
    rd_data = '0;
    repeat (3) @(negedge clk);
    check(busy == 0, "R10", "busy in reset", busy, 0);
    check(done == 0, "R10", "done in reset", done, 0);
    check(rd_en == 0, "R10", "rd_en in reset", rd_en, 0);
    check(wr_en == 0, "R10", "wr_en in reset", wr_en, 0);
    rst_n = 1'b1;
    @(negedge clk);

    fill(0); run_case(4, 4, 8, 0, 2'b00, "R3 R8", 0);
    fill(0); run_case(5, 5, 4, 0, 2'b01, "R4 R7", 0);
    fill(0); run_case(7, 6, 8, 1, 2'b01, "R5 R7 R11", 0);
    fill(1); run_case(6, 6, 4, 1, 2'b10, "R6", 0);
    fill(2); run_case(6, 6, 4, 1, 2'b10, "R6", 0);
    fill(0); run_case(6, 3, 4, 1, 2'b11, "R3 R11", 0);
    fill(3); run_case(4, 4, 4, 0, 2'b00, "R3", 0);
    fill(0); run_case(4, 6, 8, 0, 2'b10, "R1 R6", 1);
    fill(0); run_case(2, 6, 4, 1, 2'b00, "R9", 0);
    fill(0); run_case(4, 4, 2, 0, 2'b00, "R9", 0);
    fill(3); run_case(5, 7, 8, 1, 2'b01, "R5 R7", 0);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(0, "R9", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule